// File: doc/BRIEF.md
# Banked Memory Configuration Unit

This unit sits between an 8-bit CPU with a 16-bit address bus and the memories around it. On every CPU access it looks at the address and at two internal registers. It then raises exactly one target select: RAM, system ROM, internal function ROM, external function ROM, character ROM, the I/O block, or the unit's own registers. When RAM is selected, it also drives the physical RAM bank bit. A second bank bit, held in a separate register, tells a video controller which RAM bank to fetch from.

The CPU configuration register sets the CPU's RAM bank and the ROM/I/O layout. The RAM configuration register sets the video bank and a shared RAM window. Reads from a ROM-mapped window return ROM, while writes to the same address land in the RAM underneath. A preset port loads any of 16 ready-made layouts in a single write.

Register writes take effect at the next rising clock edge. Decode and read data are combinational from the current address and register state.

Top module: `bankmap_unit`

## Requirements
- R1: After a synchronous reset, both registers read 0x00. This gives RAM bank 0, video bank 0, system ROM at $4000–$FFFF, and I/O at $D000–$DFFF.
- R2: A write to a register address updates that register at the next clock edge, and a read of that address returns the stored byte on `reg_rdata`. Both $D500 and its mirror $FF00 address the CPU configuration register. $D506 addresses the RAM configuration register.
- R3: The CPU's physical RAM bank is bit 6 of the CPU configuration register. Bank values 2 and 3 therefore alias to banks 0 and 1.
- R4: Window sources are decoded from the CPU configuration register as follows. For $4000–$7FFF, bit 1 = 0 selects system ROM and bit 1 = 1 selects RAM. For $8000–$BFFF, bits 3:2 select the source, and for $C000–$FFFF, bits 5:4 select it, using 00 = system ROM, 01 = internal function ROM, 10 = external function ROM, 11 = RAM. $0000–$3FFF is always RAM.
- R5: When bits 5:4 are not 11, $D000–$DFFF selects I/O if bit 0 = 0 and character ROM if bit 0 = 1. When bits 5:4 are 11, that range is RAM.
- R6: A CPU write into any ROM window (system, internal, external or character) selects RAM in the current bank. Writes to I/O stay on I/O.
- R7: Changing only bits 7:6 of the CPU configuration register leaves the ROM and I/O selection for every address unchanged.
- R8: A write to $FF01 with value N loads preset N[3:0] into the CPU configuration register, and bits 7:4 of N are ignored. The presets for N = 0..15 are 3F 7F BF FF 16 56 96 D6 2A 6A AA EA 06 0A 01 00 (hex).
- R9: $FF00 and $FF01 always select the registers. $D500 and $D506 select the registers only when $D000–$DFFF would otherwise be I/O; in every other case they follow that range's normal decode.
- R10: RAM configuration bits 1:0 set a shared-window size of 1, 4, 8 or 16 KB (00..11). Bit 2 places a window at the bottom of the address space and bit 3 places one at the top. A RAM access inside an enabled window uses physical bank 0.
- R11: `vid_bank` equals bit 6 of the RAM configuration register and does not follow the CPU configuration register.
- R12: While `cpu_en` is high, exactly one select output is high. While `cpu_en` is low, all selects and `ram_bank` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_en | input | 1 | CPU access valid this cycle |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Register read data, zero when no register is hit |
| sel_ram | output | 1 | RAM selected |
| ram_bank | output | 1 | Physical RAM bank for the access |
| sel_sys | output | 1 | System ROM selected |
| sel_ifn | output | 1 | Internal function ROM selected |
| sel_xfn | output | 1 | External function ROM selected |
| sel_chr | output | 1 | Character ROM selected |
| sel_io | output | 1 | I/O block selected |
| sel_reg | output | 1 | Unit register selected |
| vid_bank | output | 1 | RAM bank for video fetches |

## Verification
The selects, `ram_bank` and `reg_rdata` respond to the address in the same cycle. The bench therefore drives each access on a falling edge and samples one nanosecond later, before the next rising edge. Register contents, and so `vid_bank` and any decode that depends on them, change one rising edge after a write. Every vector first performs its register writes on whole clock cycles and only then presents the access under test. Reads of the stored bytes are taken at least one edge after the write that set them.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

    typedef enum logic [2:0] {
        TGT_RAM = 3'd0,
        TGT_SYS = 3'd1,
        TGT_IFN = 3'd2,
        TGT_XFN = 3'd3,
        TGT_CHR = 3'd4,
        TGT_IO  = 3'd5,
        TGT_REG = 3'd6
    } tgt_e;

    // CPU configuration register layout
    typedef struct packed {
        logic [1:0] bank;
        logic [1:0] hi_src;
        logic [1:0] mid_src;
        logic       low_ram;
        logic       chr_on;
    } cfg_t;

    // RAM configuration register layout
    typedef struct packed {
        logic [1:0] vbank;
        logic [1:0] spare;
        logic       top_en;
        logic       bot_en;
        logic [1:0] size;
    } rcr_t;

    localparam logic [1:0] SRC_SYS = 2'd0;
    localparam logic [1:0] SRC_IFN = 2'd1;
    localparam logic [1:0] SRC_XFN = 2'd2;
    localparam logic [1:0] SRC_RAM = 2'd3;

    function automatic tgt_e src_to_tgt(input logic [1:0] src);
        case (src)
            SRC_SYS: return TGT_SYS;
            SRC_IFN: return TGT_IFN;
            SRC_XFN: return TGT_XFN;
            default: return TGT_RAM;
        endcase
    endfunction

    function automatic logic is_rom(input tgt_e t);
        return (t == TGT_SYS) || (t == TGT_IFN) || (t == TGT_XFN) || (t == TGT_CHR);
    endfunction

    // log2 of the shared window size in bytes: 1K, 4K, 8K, 16K
    function automatic logic [4:0] span_bits(input logic [1:0] size);
        case (size)
            2'd0:    return 5'd10;
            2'd1:    return 5'd12;
            2'd2:    return 5'd13;
            default: return 5'd14;
        endcase
    endfunction

    function automatic logic [7:0] preset_value(input logic [3:0] n);
        logic [5:0] layout;
        logic [1:0] bank;
        bank = 2'd0;
        case (n)
            4'd0, 4'd1, 4'd2, 4'd3: begin
                layout = {SRC_RAM, SRC_RAM, 1'b1, 1'b1};
                bank   = n[1:0];
            end
            4'd4, 4'd5, 4'd6, 4'd7: begin
                layout = {SRC_IFN, SRC_IFN, 1'b1, 1'b0};
                bank   = n[1:0];
            end
            4'd8, 4'd9, 4'd10, 4'd11: begin
                layout = {SRC_XFN, SRC_XFN, 1'b1, 1'b0};
                bank   = n[1:0];
            end
            4'd12:   layout = {SRC_SYS, SRC_IFN, 1'b1, 1'b0};
            4'd13:   layout = {SRC_SYS, SRC_XFN, 1'b1, 1'b0};
            4'd14:   layout = {SRC_SYS, SRC_SYS, 1'b0, 1'b1};
            default: layout = {SRC_SYS, SRC_SYS, 1'b0, 1'b0};
        endcase
        return {bank, layout};
    endfunction

endpackage

// File: rtl/bankmap_decode.sv
module bankmap_decode
    import bankmap_pkg::*;
#(
    parameter int          AW          = 16,
    parameter logic [15:0] CFG_ADDR    = 16'hD500,
    parameter logic [15:0] RCR_ADDR    = 16'hD506,
    parameter logic [15:0] MIRROR_ADDR = 16'hFF00,
    parameter logic [15:0] PRESET_ADDR = 16'hFF01,
    parameter logic [3:0]  IO_PAGE     = 4'hD
) (
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  cfg_t          cfg,
    input  rcr_t          rcr,
    output tgt_e          tgt,
    output logic          bank
);
    localparam int QW = AW - 2;

    tgt_e       raw;
    logic [4:0] sh;
    logic [1:0] end_en;
    logic [1:0] end_hit;

    assign sh     = span_bits(rcr.size);
    assign end_en = {rcr.top_en, rcr.bot_en};

    // index 0 probes the bottom end, index 1 the top end
    for (genvar e = 0; e < 2; e++) begin : g_end
        logic [AW-1:0] probe;
        assign probe      = (e == 0) ? addr : ~addr;
        assign end_hit[e] = end_en[e] && ((probe >> sh) == '0);
    end

    always_comb begin
        raw = TGT_RAM;
        if (addr == MIRROR_ADDR[AW-1:0] || addr == PRESET_ADDR[AW-1:0]) begin
            raw = TGT_REG;
        end else begin
            case (addr[AW-1 -: 2])
                2'b00: raw = TGT_RAM;
                2'b01: raw = cfg.low_ram ? TGT_RAM : TGT_SYS;
                2'b10: raw = src_to_tgt(cfg.mid_src);
                default: begin
                    if (addr[AW-1 -: 4] == IO_PAGE && cfg.hi_src != SRC_RAM) begin
                        if (cfg.chr_on)
                            raw = TGT_CHR;
                        else if (addr == CFG_ADDR[AW-1:0] || addr == RCR_ADDR[AW-1:0])
                            raw = TGT_REG;
                        else
                            raw = TGT_IO;
                    end else begin
                        raw = src_to_tgt(cfg.hi_src);
                    end
                end
            endcase
        end
    end

    // writes under a ROM fall through to RAM
    assign tgt  = (we && is_rom(raw)) ? TGT_RAM : raw;
    assign bank = (tgt == TGT_RAM) && !(|end_hit) && cfg.bank[0];

    logic unused_q;
    assign unused_q = ^{addr[QW-1:0] == '0};
endmodule

// File: rtl/bankmap_regs.sv
module bankmap_regs
    import bankmap_pkg::*;
#(
    parameter int          AW          = 16,
    parameter int          DW          = 8,
    parameter logic [15:0] CFG_ADDR    = 16'hD500,
    parameter logic [15:0] RCR_ADDR    = 16'hD506,
    parameter logic [15:0] MIRROR_ADDR = 16'hFF00,
    parameter logic [15:0] PRESET_ADDR = 16'hFF01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg_q,
    output rcr_t          rcr_q,
    output logic [DW-1:0] rdata
);
    logic is_cfg, is_rcr, is_pre;

    assign is_cfg = (addr == CFG_ADDR[AW-1:0]) || (addr == MIRROR_ADDR[AW-1:0]);
    assign is_rcr = (addr == RCR_ADDR[AW-1:0]);
    assign is_pre = (addr == PRESET_ADDR[AW-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            rcr_q <= '0;
        end else if (hit && we) begin
            if (is_cfg)
                cfg_q <= cfg_t'(wdata[7:0]);
            else if (is_pre)
                cfg_q <= cfg_t'(preset_value(wdata[3:0]));
            else if (is_rcr)
                rcr_q <= rcr_t'(wdata[7:0]);
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            if (is_rcr)
                rdata = DW'(rcr_q);
            else
                rdata = DW'(cfg_q);
        end
    end
endmodule

// File: rtl/bankmap_unit.sv
module bankmap_unit
    import bankmap_pkg::*;
#(
    parameter int          AW          = 16,
    parameter int          DW          = 8,
    parameter logic [15:0] CFG_ADDR    = 16'hD500,
    parameter logic [15:0] RCR_ADDR    = 16'hD506,
    parameter logic [15:0] MIRROR_ADDR = 16'hFF00,
    parameter logic [15:0] PRESET_ADDR = 16'hFF01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_en,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          sel_ram,
    output logic          ram_bank,
    output logic          sel_sys,
    output logic          sel_ifn,
    output logic          sel_xfn,
    output logic          sel_chr,
    output logic          sel_io,
    output logic          sel_reg,
    output logic          vid_bank
);
    cfg_t cfg_q;
    rcr_t rcr_q;
    tgt_e tgt;
    logic bank_raw;
    logic reg_hit;

    bankmap_decode #(
        .AW(AW), .CFG_ADDR(CFG_ADDR), .RCR_ADDR(RCR_ADDR),
        .MIRROR_ADDR(MIRROR_ADDR), .PRESET_ADDR(PRESET_ADDR), .IO_PAGE(4'hD)
    ) dec_i (
        .addr (cpu_addr),
        .we   (cpu_we),
        .cfg  (cfg_q),
        .rcr  (rcr_q),
        .tgt  (tgt),
        .bank (bank_raw)
    );

    assign reg_hit = cpu_en && (tgt == TGT_REG);

    bankmap_regs #(
        .AW(AW), .DW(DW), .CFG_ADDR(CFG_ADDR), .RCR_ADDR(RCR_ADDR),
        .MIRROR_ADDR(MIRROR_ADDR), .PRESET_ADDR(PRESET_ADDR)
    ) regs_i (
        .clk   (clk),
        .rst   (rst),
        .hit   (reg_hit),
        .we    (cpu_we),
        .addr  (cpu_addr),
        .wdata (cpu_wdata),
        .cfg_q (cfg_q),
        .rcr_q (rcr_q),
        .rdata (reg_rdata)
    );

    assign sel_ram  = cpu_en && (tgt == TGT_RAM);
    assign ram_bank = cpu_en && bank_raw;
    assign sel_sys  = cpu_en && (tgt == TGT_SYS);
    assign sel_ifn  = cpu_en && (tgt == TGT_IFN);
    assign sel_xfn  = cpu_en && (tgt == TGT_XFN);
    assign sel_chr  = cpu_en && (tgt == TGT_CHR);
    assign sel_io   = cpu_en && (tgt == TGT_IO);
    assign sel_reg  = reg_hit;
    assign vid_bank = rcr_q.vbank[0];
endmodule

// File: rtl/bankmap_chk.sv
module bankmap_chk #(
    parameter int          AW          = 16,
    parameter int          DW          = 8,
    parameter logic [15:0] RCR_ADDR    = 16'hD506,
    parameter logic [15:0] MIRROR_ADDR = 16'hFF00
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_en,
    input logic          cpu_we,
    input logic [AW-1:0] cpu_addr,
    input logic [DW-1:0] cpu_wdata,
    input logic [6:0]    sels,
    input logic          ram_bank,
    input logic          vid_bank,
    input logic [7:0]    cfg_q,
    input logic [7:0]    rcr_q
);
    // R12
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_en |-> ($countones(sels) == 1));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_en |-> (sels == '0 && !ram_bank));

    // R2
    mirror_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && cpu_we && cpu_addr == MIRROR_ADDR[AW-1:0]) |=> (cfg_q == $past(cpu_wdata[7:0])));

    // R9
    mirror_reach_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && cpu_addr == MIRROR_ADDR[AW-1:0]) |-> sels[6]);

    // R3
    bank_source_chk: assert property (@(posedge clk) disable iff (rst)
        (sels[0] && ram_bank) |-> cfg_q[6]);

    // R6 (bits 1..4 are the ROM selects)
    write_no_rom_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && cpu_we) |-> (sels[4:1] == 4'b0));

    // R10
    shared_bottom_chk: assert property (@(posedge clk) disable iff (rst)
        (sels[0] && rcr_q[2] && cpu_addr < 16'h0400) |-> !ram_bank);

    // R11
    vid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_en && cpu_we && cpu_addr == RCR_ADDR[AW-1:0]) |=> $stable(vid_bank));
endmodule

bind bankmap_unit bankmap_chk #(
    .AW(AW), .DW(DW), .RCR_ADDR(RCR_ADDR), .MIRROR_ADDR(MIRROR_ADDR)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cpu_en    (cpu_en),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .sels      ({sel_reg, sel_io, sel_chr, sel_xfn, sel_ifn, sel_sys, sel_ram}),
    .ram_bank  (ram_bank),
    .vid_bank  (vid_bank),
    .cfg_q     (cfg_q),
    .rcr_q     (rcr_q)
);

// File: tb/bankmap_unit_tb.sv
module bankmap_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_en = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        sel_ram, ram_bank, sel_sys, sel_ifn, sel_xfn, sel_chr, sel_io, sel_reg, vid_bank;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bankmap_unit dut_i (
        .clk(clk), .rst(rst), .cpu_en(cpu_en), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .reg_rdata(reg_rdata),
        .sel_ram(sel_ram), .ram_bank(ram_bank), .sel_sys(sel_sys),
        .sel_ifn(sel_ifn), .sel_xfn(sel_xfn), .sel_chr(sel_chr),
        .sel_io(sel_io), .sel_reg(sel_reg), .vid_bank(vid_bank)
    );

    // outputs packed as {reg, io, chr, xfn, ifn, sys, ram, bank}
    localparam logic [7:0] O_RAM0 = 8'h02;
    localparam logic [7:0] O_RAM1 = 8'h03;
    localparam logic [7:0] O_SYS  = 8'h04;
    localparam logic [7:0] O_IFN  = 8'h08;
    localparam logic [7:0] O_XFN  = 8'h10;
    localparam logic [7:0] O_CHR  = 8'h20;
    localparam logic [7:0] O_IO   = 8'h40;
    localparam logic [7:0] O_REG  = 8'h80;

    // {cfg, rcr, addr, we, expected outputs}
    localparam int NV = 41;
    localparam logic [40:0] VEC [NV] = '{
        {8'h00, 8'h00, 16'h0000, 1'b0, O_RAM0},  // R4
        {8'h00, 8'h00, 16'h4000, 1'b0, O_SYS },  // R4
        {8'h02, 8'h00, 16'h7FFF, 1'b0, O_RAM0},  // R4
        {8'h00, 8'h00, 16'h8000, 1'b0, O_SYS },  // R4
        {8'h04, 8'h00, 16'h9000, 1'b0, O_IFN },  // R4
        {8'h08, 8'h00, 16'hA000, 1'b0, O_XFN },  // R4
        {8'h0C, 8'h00, 16'hBFFF, 1'b0, O_RAM0},  // R4
        {8'h10, 8'h00, 16'hC000, 1'b0, O_IFN },  // R4
        {8'h20, 8'h00, 16'hE000, 1'b0, O_XFN },  // R4
        {8'h30, 8'h00, 16'hF000, 1'b0, O_RAM0},  // R4
        {8'h00, 8'h00, 16'hD000, 1'b0, O_IO  },  // R5
        {8'h01, 8'h00, 16'hD800, 1'b0, O_CHR },  // R5
        {8'h31, 8'h00, 16'hD800, 1'b0, O_RAM0},  // R5
        {8'h00, 8'h00, 16'h4000, 1'b1, O_RAM0},  // R6
        {8'h40, 8'h00, 16'h8000, 1'b1, O_RAM1},  // R6
        {8'h41, 8'h00, 16'hD000, 1'b1, O_RAM1},  // R6
        {8'h40, 8'h00, 16'hD800, 1'b1, O_IO  },  // R6
        {8'h40, 8'h00, 16'h8000, 1'b0, O_SYS },  // R7
        {8'hC0, 8'h00, 16'h1000, 1'b0, O_RAM1},  // R3
        {8'h80, 8'h00, 16'h1000, 1'b0, O_RAM0},  // R3
        {8'h7F, 8'h05, 16'h0FFF, 1'b0, O_RAM0},  // R10
        {8'h7F, 8'h05, 16'h1000, 1'b0, O_RAM1},  // R10
        {8'h7F, 8'h0B, 16'hC000, 1'b0, O_RAM0},  // R10
        {8'h7F, 8'h0B, 16'hBFFF, 1'b0, O_RAM1},  // R10
        {8'h7F, 8'h0E, 16'h1FFF, 1'b0, O_RAM0},  // R10
        {8'h7F, 8'h0E, 16'h2000, 1'b0, O_RAM1},  // R10
        {8'h7F, 8'h0E, 16'hDFFF, 1'b0, O_RAM1},  // R10
        {8'h7F, 8'h0E, 16'hE000, 1'b0, O_RAM0},  // R10
        {8'h7F, 8'h0C, 16'h03FF, 1'b0, O_RAM0},  // R10
        {8'h7F, 8'h0C, 16'h0400, 1'b0, O_RAM1},  // R10
        {8'h7F, 8'h0C, 16'hFC00, 1'b0, O_RAM0},  // R10
        {8'h7F, 8'h00, 16'h0000, 1'b0, O_RAM1},  // R10
        {8'h7F, 8'h05, 16'h0FFF, 1'b1, O_RAM0},  // R10
        {8'h3F, 8'h00, 16'hFF00, 1'b0, O_REG },  // R9
        {8'hFF, 8'h00, 16'hFF01, 1'b0, O_REG },  // R9
        {8'h3F, 8'h00, 16'hD500, 1'b0, O_RAM0},  // R9
        {8'h00, 8'h00, 16'hD500, 1'b0, O_REG },  // R9
        {8'h00, 8'h00, 16'hD506, 1'b1, O_REG },  // R9
        {8'h00, 8'h00, 16'hD501, 1'b0, O_IO  },  // R9
        {8'h01, 8'h00, 16'hD500, 1'b0, O_CHR },  // R9
        {8'h30, 8'h00, 16'hD500, 1'b0, O_RAM0}   // R9
    };

    localparam logic [7:0] PRESETS [16] = '{
        8'h3F, 8'h7F, 8'hBF, 8'hFF, 8'h16, 8'h56, 8'h96, 8'hD6,
        8'h2A, 8'h6A, 8'hAA, 8'hEA, 8'h06, 8'h0A, 8'h01, 8'h00
    };

    function automatic logic [7:0] outs();
        return {sel_reg, sel_io, sel_chr, sel_xfn, sel_ifn, sel_sys, sel_ram, ram_bank};
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_en = 1'b0; cpu_we = 1'b0; cpu_wdata = '0;
    endtask

    task automatic access(input logic [15:0] a, input logic w);
        @(negedge clk);
        cpu_en = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = '0;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_en = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 vid_bank", {15'b0, vid_bank}, 16'h0);
        access(16'hD500, 1'b0);
        check("R1 cfg read", {8'h0, reg_rdata}, 16'h00);
        check("R1 cfg sel", {8'h0, outs()}, {8'h0, O_REG});
        access(16'hD506, 1'b0);
        check("R1 rcr read", {8'h0, reg_rdata}, 16'h00);
        access(16'hE000, 1'b0);
        check("R1 high ROM", {8'h0, outs()}, {8'h0, O_SYS});
        idle();

        // R12 idle
        cpu_addr = 16'h4000;
        #1;
        check("R12 idle", {8'h0, outs()}, 16'h0);

        // R2 write and read back
        wr(16'hFF00, 8'h5A);
        access(16'hFF00, 1'b0);
        check("R2 mirror read", {8'h0, reg_rdata}, 16'h5A);
        wr(16'hFF00, 8'h00);
        wr(16'hD500, 8'h24);
        access(16'hFF00, 1'b0);
        check("R2 D500 via mirror", {8'h0, reg_rdata}, 16'h24);
        wr(16'hFF00, 8'h00);
        wr(16'hD506, 8'h93);
        access(16'hD506, 1'b0);
        check("R2 rcr read", {8'h0, reg_rdata}, 16'h93);

        // R11 video bank independent of CPU bank
        wr(16'hD506, 8'h40);
        check("R11 vid set", {15'b0, vid_bank}, 16'h1);
        wr(16'hFF00, 8'h00);
        check("R11 vid after cpu bank0", {15'b0, vid_bank}, 16'h1);
        access(16'h1000, 1'b0);
        check("R11 cpu bank0", {8'h0, outs()}, {8'h0, O_RAM0});
        wr(16'hFF00, 8'hC0);
        wr(16'hFF00, 8'h00);
        wr(16'hD506, 8'h00);
        check("R11 vid clear", {15'b0, vid_bank}, 16'h0);
        wr(16'hFF00, 8'h40);
        check("R11 vid stays with cpu bank1", {15'b0, vid_bank}, 16'h0);

        // Table walk: R3 R4 R5 R6 R7 R9 R10
        for (int i = 0; i < NV; i++) begin
            wr(16'hFF00, 8'h00);
            wr(16'hD506, VEC[i][32:25]);
            wr(16'hFF00, VEC[i][40:33]);
            access(VEC[i][24:9], VEC[i][8]);
            check($sformatf("vector %0d (R3..R10) addr %h", i, VEC[i][24:9]),
                  {8'h0, outs()}, {8'h0, VEC[i][7:0]});
            idle();
        end

        // R8 presets, high nibble ignored
        for (int n = 0; n < 16; n++) begin
            wr(16'hFF01, 8'hA0 | 8'(n));
            access(16'hFF00, 1'b0);
            check($sformatf("R8 preset %0d", n), {8'h0, reg_rdata}, {8'h0, PRESETS[n]});
            idle();
        end
        wr(16'hFF01, 8'h0E);
        access(16'hD000, 1'b0);
        check("R8 preset 14 char ROM", {8'h0, outs()}, {8'h0, O_CHR});
        wr(16'hFF01, 8'h05);
        access(16'h8000, 1'b0);
        check("R8 preset 5 ifn", {8'h0, outs()}, {8'h0, O_IFN});
        access(16'h8000, 1'b1);
        check("R8 preset 5 write bank1", {8'h0, outs()}, {8'h0, O_RAM1});
        idle();

        // R12 one-hot with access, then idle again
        access(16'hC000, 1'b0);
        check("R12 active onehot", {12'h0, 4'($countones(outs() & 8'hFE))}, 16'h1);
        idle();
        #1;
        check("R12 idle again", {8'h0, outs()}, 16'h0);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        access(16'hFF00, 1'b0);
        check("R1 reset again", {8'h0, reg_rdata}, 16'h00);
        idle();

        finish_run();
    end
endmodule